// File: doc/BRIEF.md
# Card Access Timing Calculator

This block turns a requested card access time, given in nanoseconds, and the bus clock frequency, given in kHz, into the two timing values a card window needs: a command length in bus cycles and a command delay code. It packs them into one 16-bit window control word together with the address space the window serves (attribute memory, common memory or I/O) and a wait-request enable bit that is always set.

A request starts with a one-cycle `calc_go` pulse. The block first applies a window-dependent default access time when the request is zero, then limits the time to the range 100 to 600 ns. It forms the product of the limited time and the frequency and divides that product by 1,000,000 in a serial restoring divider, one quotient bit per cycle. The quotient is rounded up whenever a remainder is left and is then saturated to the 6-bit field. The result appears on `ctl_word` with a one-cycle `calc_done` strobe a fixed number of cycles after the start. The word is held until the next result.

The controller has three states. ST_IDLE waits for `calc_go`; the transition ST_IDLE to ST_DIVIDE loads the divider with the product. ST_DIVIDE resolves one quotient bit per cycle from the most significant bit down; it stays there until the last bit, then takes the transition ST_DIVIDE to ST_FINISH. ST_FINISH rounds, saturates and registers the word, raises `calc_done`, and always returns to ST_IDLE.

Top module: `acc_timing_calc`

## Requirements
- R1: After reset `ctl_word` is 0 and `calc_done` is 0.
- R2: A `calc_go` accepted in the idle state yields `calc_done` high for exactly one cycle, 8 clock edges after the edge that sampled `calc_go` (7 quotient steps plus one finishing step).
- R3: A `calc_go` that arrives while a calculation is in progress is ignored: it produces no extra result and does not alter the result in flight.
- R4: A requested time of 0 selects the window default: 300 ns for window index 0 and 100 ns for every other index.
- R5: The access time used is limited to a minimum of 100 ns and a maximum of 600 ns.
- R6: The command length in `ctl_word[5:0]` equals ceiling(ns × kHz / 1,000,000), where ns is the limited time; an exact quotient is not rounded up.
- R7: A command length above 63 is saturated to 63.
- R8: The delay code in `ctl_word[7:6]` is 1 when the limited time is at the minimum of 100 ns and 2 otherwise.
- R9: The space code in `ctl_word[9:8]` is 0 for index 0 (attribute memory), 1 for index 1 (common memory) and 2 for index 2 (I/O); index 3 is treated as I/O and also gives 2.
- R10: Every result has the wait-request enable bit `ctl_word[10]` set to 1 and bits 15:11 at 0.
- R11: `ctl_word` keeps its value between results, whatever the inputs do while no calculation completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| calc_go | input | 1 | Start pulse, taken only when idle |
| req_ns | input | 10 | Requested access time in ns; 0 selects the window default |
| bus_khz | input | 17 | Bus clock frequency in kHz |
| win_idx | input | 2 | Window index: 0 attribute, 1 common memory, 2 I/O |
| ctl_word | output | 16 | Packed window control word |
| calc_done | output | 1 | One-cycle result strobe |

## Verification
The bench aims at the rounding edge: a product that divides exactly (200 ns at 20 MHz gives 4) against one that overshoots by a small remainder (101 ns at 10 MHz gives 2); a divider that always adds one, or drops the remainder test, misses one of them. It drives lengths of exactly 63 and just above it, where a missing saturation would wrap to a small value, and a zero frequency that must give length 0. Requests below 100 and above 600 ns, and zero requests on each window index, catch a wrong limit, a wrong default or a delay code taken from the unlimited time. A second start during a calculation and input changes between results show whether the design restarts, emits a spurious strobe or lets the word drift.

// File: rtl/acc_timing_pkg.sv
package acc_timing_pkg;

    parameter int NS_W     = 10;        // access time input width
    parameter int KHZ_W    = 17;        // frequency input width
    parameter int LEN_W    = 6;         // command length field width
    parameter int QW       = 7;         // quotient bits resolved by the divider
    parameter int IDX_W    = 2;         // window index width
    parameter int unsigned NS_MIN   = 100;
    parameter int unsigned NS_MAX   = 600;
    parameter int unsigned NS_ATTR  = 300;
    parameter int unsigned NS_DFLT  = 100;
    parameter int unsigned DIVISOR  = 1_000_000;

    localparam int PROD_W  = NS_W + KHZ_W;
    localparam int SEL_W   = (QW > 1) ? $clog2(QW) : 1;
    localparam int LATENCY = QW + 1;
    localparam int WORD_W  = 16;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DIVIDE = 2'd1,
        ST_FINISH = 2'd2
    } calc_state_e;

    typedef enum logic [1:0] {
        SP_ATTR   = 2'd0,
        SP_COMMON = 2'd1,
        SP_IO     = 2'd2
    } space_e;

    typedef struct packed {
        logic [WORD_W-LEN_W-6:0] rsvd;
        logic                    wait_en;
        space_e                  space;
        logic [1:0]              dly;
        logic [LEN_W-1:0]        len;
    } win_word_t;

endpackage

// File: rtl/acc_ns_clamp.sv
module acc_ns_clamp
    import acc_timing_pkg::*;
#(
    parameter int          P_NS_W   = NS_W,
    parameter int          P_IDX_W  = IDX_W,
    parameter int unsigned P_MIN    = NS_MIN,
    parameter int unsigned P_MAX    = NS_MAX,
    parameter int unsigned P_ATTR   = NS_ATTR,
    parameter int unsigned P_DFLT   = NS_DFLT
) (
    input  logic [P_NS_W-1:0]  req_ns,
    input  logic [P_IDX_W-1:0] win_idx,
    output logic [P_NS_W-1:0]  eff_ns,
    output logic               at_min
);

    localparam logic [P_NS_W-1:0] MIN_V  = P_NS_W'(P_MIN);
    localparam logic [P_NS_W-1:0] MAX_V  = P_NS_W'(P_MAX);
    localparam logic [P_NS_W-1:0] ATTR_V = P_NS_W'(P_ATTR);
    localparam logic [P_NS_W-1:0] DFLT_V = P_NS_W'(P_DFLT);

    logic [P_NS_W-1:0] base_ns;

    always_comb begin
        if (req_ns == '0) begin
            base_ns = (win_idx == '0) ? ATTR_V : DFLT_V;
        end else begin
            base_ns = req_ns;
        end

        if (base_ns < MIN_V) begin
            eff_ns = MIN_V;
        end else if (base_ns > MAX_V) begin
            eff_ns = MAX_V;
        end else begin
            eff_ns = base_ns;
        end

        at_min = (eff_ns <= MIN_V);
    end

endmodule

// File: rtl/acc_serial_div.sv
module acc_serial_div
    import acc_timing_pkg::*;
#(
    parameter int          P_NUM_W = PROD_W,
    parameter int          P_QW    = QW,
    parameter int          P_SEL_W = SEL_W,
    parameter int unsigned P_DIV   = DIVISOR
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [P_NUM_W-1:0] numer,
    input  logic [P_SEL_W-1:0] bit_sel,
    output logic [P_QW-1:0]    quo,
    output logic               rem_nz
);

    localparam int EXT_W = P_NUM_W + P_QW;

    logic [P_NUM_W-1:0] rem_q;
    logic [P_QW-1:0]    quo_q;
    logic [EXT_W-1:0]   trial;
    logic [EXT_W-1:0]   rem_ext;
    logic               fits;

    always_comb begin
        trial   = EXT_W'(P_DIV) << bit_sel;
        rem_ext = EXT_W'(rem_q);
        fits    = (rem_ext >= trial);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
        end else if (load) begin
            rem_q <= numer;
            quo_q <= '0;
        end else if (step && fits) begin
            rem_q          <= P_NUM_W'(rem_ext - trial);
            quo_q[bit_sel] <= 1'b1;
        end
    end

    assign quo    = quo_q;
    assign rem_nz = (rem_q != '0);

endmodule

// File: rtl/acc_word_pack.sv
module acc_word_pack
    import acc_timing_pkg::*;
#(
    parameter int P_QW    = QW,
    parameter int P_LEN_W = LEN_W
) (
    input  logic [P_QW-1:0] quo,
    input  logic            rem_nz,
    input  logic            at_min,
    input  space_e          space,
    output win_word_t       word
);

    localparam logic [P_QW:0] LEN_MAX = (P_QW + 1)'((1 << P_LEN_W) - 1);

    logic [P_QW:0] len_up;

    always_comb begin
        len_up       = {1'b0, quo} + {{P_QW{1'b0}}, rem_nz};
        word         = '0;
        word.len     = (len_up > LEN_MAX) ? P_LEN_W'(LEN_MAX) : P_LEN_W'(len_up);
        word.dly     = at_min ? 2'd1 : 2'd2;
        word.space   = space;
        word.wait_en = 1'b1;
    end

endmodule

// File: rtl/acc_timing_calc.sv
module acc_timing_calc
    import acc_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              calc_go,
    input  logic [NS_W-1:0]   req_ns,
    input  logic [KHZ_W-1:0]  bus_khz,
    input  logic [IDX_W-1:0]  win_idx,
    output logic [WORD_W-1:0] ctl_word,
    output logic              calc_done
);

    calc_state_e       state_q, state_d;
    logic [SEL_W-1:0]  bit_q, bit_d;
    logic              at_min_q;
    space_e            space_q;
    logic [NS_W-1:0]   eff_ns;
    logic              at_min_c;
    logic [PROD_W-1:0] product;
    logic              div_load, div_step;
    logic [QW-1:0]     quo;
    logic              rem_nz;
    win_word_t         packed_word;
    win_word_t         word_q;
    logic              done_q;
    space_e            space_c;

    acc_ns_clamp u_clamp (
        .req_ns  (req_ns),
        .win_idx (win_idx),
        .eff_ns  (eff_ns),
        .at_min  (at_min_c)
    );

    assign product = PROD_W'(eff_ns) * PROD_W'(bus_khz);

    always_comb begin
        unique case (win_idx)
            2'd0:    space_c = SP_ATTR;
            2'd1:    space_c = SP_COMMON;
            default: space_c = SP_IO;
        endcase
    end

    acc_serial_div u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (div_load),
        .step    (div_step),
        .numer   (product),
        .bit_sel (bit_q),
        .quo     (quo),
        .rem_nz  (rem_nz)
    );

    acc_word_pack u_pack (
        .quo    (quo),
        .rem_nz (rem_nz),
        .at_min (at_min_q),
        .space  (space_q),
        .word   (packed_word)
    );

    // next-state logic
    always_comb begin
        state_d  = state_q;
        bit_d    = bit_q;
        div_load = 1'b0;
        div_step = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (calc_go) begin
                    div_load = 1'b1;
                    bit_d    = SEL_W'(QW - 1);
                    state_d  = ST_DIVIDE;
                end
            end
            ST_DIVIDE: begin
                div_step = 1'b1;
                if (bit_q == '0) begin
                    state_d = ST_FINISH;
                end else begin
                    bit_d = bit_q - 1'b1;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            bit_q    <= '0;
            at_min_q <= 1'b0;
            space_q  <= SP_ATTR;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
            if (div_load) begin
                at_min_q <= at_min_c;
                space_q  <= space_c;
            end
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_FINISH);
            if (state_q == ST_FINISH) begin
                word_q <= packed_word;
            end
        end
    end

    assign ctl_word  = word_q;
    assign calc_done = done_q;

endmodule

// File: rtl/acc_timing_chk.sv
module acc_timing_chk
    import acc_timing_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              calc_go,
    input logic [WORD_W-1:0] ctl_word,
    input logic              calc_done
);

    logic       armed;
    logic [7:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cyc   <= '0;
        end else if (calc_go && (!armed || calc_done)) begin
            armed <= 1'b1;
            cyc   <= '0;
        end else if (calc_done) begin
            armed <= 1'b0;
        end else if (armed && cyc != 8'hFF) begin
            cyc <= cyc + 8'd1;
        end
    end

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        calc_done |=> !calc_done);

    // R2 latency, and R3: a start taken while busy would shift the window
    a_r3_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
        calc_done |-> (armed && cyc == 8'(LATENCY)));

    a_r8_delay_code: assert property (@(posedge clk) disable iff (!rst_n)
        calc_done |-> (ctl_word[7:6] == 2'd1 || ctl_word[7:6] == 2'd2));

    a_r9_space_code: assert property (@(posedge clk) disable iff (!rst_n)
        calc_done |-> (ctl_word[9:8] != 2'd3));

    a_r10_wait_bit: assert property (@(posedge clk) disable iff (!rst_n)
        calc_done |-> (ctl_word[10] && ctl_word[15:11] == 5'd0));

    a_r11_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !calc_done |-> $stable(ctl_word));

endmodule

bind acc_timing_calc acc_timing_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .calc_go   (calc_go),
    .ctl_word  (ctl_word),
    .calc_done (calc_done)
);

// File: tb/acc_timing_calc_tb.sv
`timescale 1ns/1ps
module acc_timing_calc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        calc_go = 1'b0;
    logic [9:0]  req_ns = '0;
    logic [16:0] bus_khz = '0;
    logic [1:0]  win_idx = '0;
    logic [15:0] ctl_word;
    logic        calc_done;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] last_exp = '0;

    always #4 clk = ~clk;

    acc_timing_calc u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .calc_go   (calc_go),
        .req_ns    (req_ns),
        .bus_khz   (bus_khz),
        .win_idx   (win_idx),
        .ctl_word  (ctl_word),
        .calc_done (calc_done)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input int req, input int khz, input int idx);
        longint ns, p, len;
        int dly, sp;
        ns = (req == 0) ? ((idx == 0) ? 300 : 100) : req;
        if (ns < 100) ns = 100;
        if (ns > 600) ns = 600;
        p   = ns * khz;
        len = (p + 999999) / 1000000;
        if (len > 63) len = 63;
        dly = (ns <= 100) ? 1 : 2;
        sp  = (idx == 3) ? 2 : idx;
        return {5'b0, 1'b1, 2'(sp), 2'(dly), 6'(len)};
    endfunction

    // monitor: pops one expected word per strobe
    always @(negedge clk) begin
        if (rst_n && calc_done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected strobe", 32'(ctl_word), 32'h0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(ctl_word == e, t, 32'(ctl_word), 32'(e));
            end
        end
    end

    task automatic run(input int req, input int khz, input int idx, input string tag);
        int n;
        @(negedge clk);
        req_ns  = 10'(req);
        bus_khz = 17'(khz);
        win_idx = 2'(idx);
        calc_go = 1'b1;
        last_exp = model(req, khz, idx);
        exp_q.push_back(last_exp);
        tag_q.push_back(tag);
        @(negedge clk);
        calc_go = 1'b0;
        n = 1;
        while (!calc_done && n < 50) begin
            @(negedge clk);
            n++;
        end
        // go sampled at edge 0, strobe after edge 8: seen at the 9th negedge
        check(n == 9, "R2 latency", 32'(n), 32'd9);
        @(negedge clk);
        check(!calc_done, "R2 strobe width", 32'(calc_done), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 32'd0, 32'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(ctl_word == 16'h0, "R1 reset word", 32'(ctl_word), 32'h0);
        check(calc_done == 1'b0, "R1 reset strobe", 32'(calc_done), 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4 defaults: idx0 -> 300 ns, 25 MHz -> 7.5 -> 8, delay 2, space 0
        run(0, 25000, 0, "R4 default attr");
        // R4 idx1 -> 100 ns -> 2.5 -> 3, delay 1 (R8)
        run(0, 25000, 1, "R4 R8 default common");
        run(0, 33000, 2, "R4 default io");
        // R5 below minimum, R8 delay 1, exact 4
        run(50, 40000, 2, "R5 R8 clamp low");
        // R5 above maximum: 600 ns at 10 MHz -> 6
        run(1000, 10000, 1, "R5 clamp high");
        // R6 exact quotient not rounded: 200 ns at 20 MHz -> 4
        run(200, 20000, 1, "R6 exact");
        // R6 tiny remainder rounds up: 1,010,000 -> 2, R8 delay 2
        run(101, 10000, 0, "R6 R8 round up");
        // R6 zero frequency -> 0
        run(300, 0, 1, "R6 zero freq");
        // R7 exactly 63, then just above, then well above
        run(600, 105000, 2, "R7 at limit");
        run(600, 105001, 2, "R7 just above");
        run(600, 120000, 0, "R7 saturate");
        // R9 index 3 treated as I/O
        run(150, 16000, 3, "R9 index three");
        // R10 covered by every model word: wait bit set, top bits zero
        run(450, 37500, 1, "R10 mid values");

        // R3: second start during a calculation
        begin
            int n;
            @(negedge clk);
            req_ns = 10'd250; bus_khz = 17'd30000; win_idx = 2'd1; calc_go = 1'b1;
            last_exp = model(250, 30000, 1);
            exp_q.push_back(last_exp);
            tag_q.push_back("R3 first result kept");
            @(negedge clk);
            calc_go = 1'b0;
            n = 1;
            repeat (2) begin @(negedge clk); n++; end
            req_ns = 10'd600; bus_khz = 17'd120000; win_idx = 2'd0; calc_go = 1'b1;
            @(negedge clk);
            n++;
            calc_go = 1'b0;
            while (!calc_done && n < 50) begin @(negedge clk); n++; end
            check(n == 9, "R3 latency not restarted", 32'(n), 32'd9);
            repeat (14) @(negedge clk);
            check(exp_q.size() == 0, "R3 queue drained", 32'(exp_q.size()), 32'd0);
        end

        // R11: inputs move, no start: word unchanged
        req_ns = 10'd123; bus_khz = 17'd11111; win_idx = 2'd2;
        repeat (6) @(negedge clk);
        check(ctl_word == last_exp, "R11 hold", 32'(ctl_word), 32'(last_exp));
        check(!calc_done, "R11 no strobe", 32'(calc_done), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule